// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Shift Controller

This block moves one byte at a time over a four-wire serial link. It works either as the clock-driving master or as a selected slave. The processor reaches it through two byte registers. The data register starts a transfer when written and returns the last fully received byte when read. The status register reports a completion flag and a write-collision flag, and it holds a speed-doubling control bit.

In master mode the block makes its own serial clock. The clock idles low. Data is driven most significant bit first, changes on falling edges and is sampled on rising edges. The clock runs at a quarter of the system clock, or at half of it when the doubling bit is set. In slave mode the shift register follows an external serial clock, which is synchronized into the system clock domain, for as long as the select input is low.

The flags are cleared by a two-step sequence. First a status read must see a flag set. Then any access to the data register clears that flag. A dedicated acknowledge pulse also clears the completion flag. An interrupt request follows the completion flag when the interrupt enable is high. The register port is a strobe interface with no back-pressure: every read or write strobe is taken in the cycle it is asserted, and a data write made during a transfer is flagged and dropped rather than stalled.

Top module: `spi_xfer_ctl`

## Requirements
- R1: In master mode, a data-register write while idle starts a transfer. The serial clock idles low and the byte leaves on the serial output most significant bit first, so a loop-back returns it unchanged.
- R2: The master serial clock period is 4 system clock cycles when status bit 0 is clear and 2 cycles when it is set.
- R3: The receive buffer loads only on the final sampling edge of a byte. A data-register read returns the buffer, so during a later transfer it still shows the previous byte.
- R4: Status bit 7, the completion flag, becomes 1 once a byte transfer finishes.
- R5: Each flag clears only when a status read has seen that flag at 1 and a data-register read or write follows. A data access without such a prior status read leaves the flag set.
- R6: A data-register write during a transfer sets status bit 6, the collision flag, and is ignored: the byte being shifted and the received result are unchanged.
- R7: A one-cycle pulse on the acknowledge input clears the completion flag.
- R8: The interrupt request equals the completion flag ANDed with the interrupt enable input.
- R9: In master mode, a low level on the select input sets the completion flag.
- R10: After reset all status bits read 0. Status bits 5 to 1 always read 0. A status write changes only bit 0.
- R11: In slave mode with select low, the block sends its loaded byte most significant bit first on the external clock and loads the received byte into the buffer, then sets the completion flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_i | input | 1 | 1 selects master mode, 0 selects slave mode |
| irq_en_i | input | 1 | Interrupt enable |
| reg_sel_i | input | 1 | Register select: 0 status, 1 data |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Interrupt request |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | External serial clock used in slave mode |
| ss_n_i | input | 1 | Active-low select input |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |

## Verification
The assertions watch the cycle-level rules on every clock. They check that the serial clock stays low while the master is idle, that the receive buffer changes only on a final sampling edge, and that a completion, a collision or an acknowledge shows up in the flags one cycle later. They also check that an unarmed completion flag cannot drop on its own and that a colliding write leaves the shift register alone. Only the bench scenarios show the end-to-end behaviour: the looped-back bytes, the measured clock periods at both speeds, the two-step clear and its per-flag arming, the forced flag from a low select, and a slave-mode exchange driven by an external clock.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef enum logic {SEL_STATUS = 1'b0, SEL_DATA = 1'b1} reg_sel_e;

  function automatic logic [7:0] pack_status(input logic done_f, input logic coll_f,
                                             input logic dbl_b);
    return {done_f, coll_f, 5'b00000, dbl_b};
  endfunction
endpackage

// File: rtl/spi_xfer_sync.sv
module spi_xfer_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] st;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[i] <= RST_VAL;
        else        st[i] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[i] <= RST_VAL;
        else        st[i] <= st[i-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/spi_xfer_clkgen.sv
module spi_xfer_clkgen #(
  parameter int DIV_SLOW = 4,
  parameter int DIV_FAST = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic fast_i,
  output logic active_o,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int HALF_S = DIV_SLOW / 2;
  localparam int HALF_F = DIV_FAST / 2;
  localparam int CW     = (HALF_S > 1) ? $clog2(HALF_S) : 1;
  localparam logic [CW-1:0] HS_M1 = CW'(HALF_S - 1);
  localparam logic [CW-1:0] HF_M1 = CW'(HALF_F - 1);

  logic [CW-1:0] cnt;
  logic          active, sck;
  logic          expire;

  assign expire   = active && (cnt >= (fast_i ? HF_M1 : HS_M1));
  assign rise_o   = expire && !sck;
  assign fall_o   = expire && sck;
  assign active_o = active;
  assign sck_o    = sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sck    <= 1'b0;
      cnt    <= '0;
    end else if (start_i) begin
      active <= 1'b1;
      sck    <= 1'b0;
      cnt    <= '0;
    end else if (active) begin
      if (stop_i) begin
        active <= 1'b0;
        sck    <= 1'b0;
        cnt    <= '0;
      end else if (expire) begin
        sck <= ~sck;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1: serial clock rests low whenever the master is idle
  a_r1_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sck);
endmodule

// File: rtl/spi_xfer_shifter.sv
module spi_xfer_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sdi_i,
  output logic [DATA_W-1:0] shreg_o,
  output logic [DATA_W-1:0] rxbuf_o,
  output logic              cnt_nz_o,
  output logic              done_o
);
  localparam int CNTW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(DATA_W - 1);

  logic [DATA_W-1:0] shreg, rxbuf;
  logic [CNTW-1:0]   bcnt;
  logic              samp;
  logic              last_bit;

  assign last_bit = (bcnt == LAST);
  assign done_o   = fall_i && last_bit;
  assign cnt_nz_o = (bcnt != '0);
  assign shreg_o  = shreg;
  assign rxbuf_o  = rxbuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      rxbuf <= '0;
      bcnt  <= '0;
      samp  <= 1'b0;
    end else if (load_i) begin
      shreg <= load_data_i;
      bcnt  <= '0;
    end else if (clr_i) begin
      bcnt <= '0;
    end else begin
      if (rise_i) begin
        samp <= sdi_i;
        if (last_bit) rxbuf <= {shreg[DATA_W-2:0], sdi_i};
      end
      if (fall_i) begin
        shreg <= {shreg[DATA_W-2:0], samp};
        bcnt  <= last_bit ? '0 : bcnt + 1'b1;
      end
    end
  end

  // R3: the receive buffer moves only on the final sampling edge
  a_r3_rxbuf_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_i && last_bit) |=> $stable(rxbuf));
endmodule

// File: rtl/spi_xfer_flags.sv
module spi_xfer_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  input  logic force_i,
  input  logic collide_i,
  input  logic stat_rd_i,
  input  logic stat_wr_i,
  input  logic wbit_i,
  input  logic data_acc_i,
  input  logic ack_i,
  output logic done_f_o,
  output logic coll_f_o,
  output logic dbl_o
);
  logic done_f, coll_f, arm_done, arm_coll, dbl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_f   <= 1'b0;
      coll_f   <= 1'b0;
      arm_done <= 1'b0;
      arm_coll <= 1'b0;
      dbl      <= 1'b0;
    end else begin
      done_f <= (done_f && !ack_i && !(data_acc_i && arm_done)) || done_i || force_i;
      coll_f <= (coll_f && !(data_acc_i && arm_coll)) || collide_i;
      if (data_acc_i || ack_i)      arm_done <= 1'b0;
      else if (stat_rd_i && done_f) arm_done <= 1'b1;
      if (data_acc_i)               arm_coll <= 1'b0;
      else if (stat_rd_i && coll_f) arm_coll <= 1'b1;
      if (stat_wr_i) dbl <= wbit_i;
    end
  end

  assign done_f_o = done_f;
  assign coll_f_o = coll_f;
  assign dbl_o    = dbl;

  // R4: a finished byte raises the completion flag
  a_r4_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> done_f);
  // R6: a colliding write raises the collision flag
  a_r6_coll_sets: assert property (@(posedge clk) disable iff (!rst_n)
    collide_i |=> coll_f);
  // R7: acknowledge drops the completion flag
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !done_i && !force_i) |=> !done_f);
  // R5: without arming, the completion flag cannot fall
  a_r5_unarmed_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (done_f && !arm_done && !ack_i) |=> done_f);
endmodule

// File: rtl/spi_xfer_ctl.sv
module spi_xfer_ctl
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_SLOW    = 4,
  parameter int DIV_FAST    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       master_i,
  input  logic       irq_en_i,
  input  logic       reg_sel_i,
  input  logic       reg_wr_i,
  input  logic       reg_rd_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o,
  input  logic       irq_ack_i,
  output logic       sck_o,
  input  logic       sck_i,
  input  logic       ss_n_i,
  output logic       sdo_o,
  input  logic       sdi_i
);
  logic ss_s, sck_s, sck_d;
  logic m_active, m_sck, m_rise, m_fall;
  logic s_sel, s_rise, s_fall, rise, fall;
  logic cnt_nz, done, busy;
  logic data_wr, data_rd, stat_wr, stat_rd, collide, load;
  logic done_f, coll_f, dbl;
  logic [DATA_W-1:0] shreg, rxbuf;
  reg_sel_e sel;

  spi_xfer_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ss_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ss_n_i), .q_o(ss_s));
  spi_xfer_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sck_i), .q_o(sck_s));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;

  assign sel     = reg_sel_e'(reg_sel_i);
  assign data_wr = reg_wr_i && (sel == SEL_DATA);
  assign data_rd = reg_rd_i && (sel == SEL_DATA);
  assign stat_wr = reg_wr_i && (sel == SEL_STATUS);
  assign stat_rd = reg_rd_i && (sel == SEL_STATUS);

  assign s_sel  = !master_i && !ss_s;
  assign s_rise = s_sel && sck_s && !sck_d;
  assign s_fall = s_sel && !sck_s && sck_d;
  assign rise   = master_i ? m_rise : s_rise;
  assign fall   = master_i ? m_fall : s_fall;
  assign busy   = master_i ? m_active : cnt_nz;

  assign collide = data_wr && busy;
  assign load    = data_wr && !busy;

  spi_xfer_clkgen #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .start_i(load && master_i), .stop_i(done),
    .fast_i(dbl), .active_o(m_active), .sck_o(m_sck), .rise_o(m_rise),
    .fall_o(m_fall));

  spi_xfer_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_data_i(reg_wdata_i[DATA_W-1:0]),
    .clr_i(!master_i && ss_s), .rise_i(rise), .fall_i(fall), .sdi_i(sdi_i),
    .shreg_o(shreg), .rxbuf_o(rxbuf), .cnt_nz_o(cnt_nz), .done_o(done));

  spi_xfer_flags u_flags (
    .clk(clk), .rst_n(rst_n), .done_i(done), .force_i(master_i && !ss_s),
    .collide_i(collide), .stat_rd_i(stat_rd), .stat_wr_i(stat_wr),
    .wbit_i(reg_wdata_i[0]), .data_acc_i(data_wr || data_rd), .ack_i(irq_ack_i),
    .done_f_o(done_f), .coll_f_o(coll_f), .dbl_o(dbl));

  assign reg_rdata_o = (sel == SEL_DATA) ? 8'(rxbuf) : pack_status(done_f, coll_f, dbl);
  assign irq_o       = done_f && irq_en_i;
  assign sck_o       = m_sck;
  assign sdo_o       = shreg[DATA_W-1];

  // R6: a write that collides leaves the byte in flight untouched
  a_r6_inflight_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && !fall) |=> $stable(shreg));
endmodule

// File: tb/spi_xfer_ctl_tb_top.sv
`timescale 1ns/1ps
module spi_xfer_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master_m = 1'b1, irq_en = 1'b1, sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, ack = 1'b0, sck, sck_ext = 1'b0, ss_n = 1'b1, sdo, tb_sdi = 1'b0;
  logic       sdi;

  int total = 0, bad = 0;
  bit ended = 0;
  logic [7:0] exp_q[$];
  logic [7:0] mon_byte = 8'h00;
  int   mon_bits = 0;
  time  last_rise = 0, last_per = 0;

  always #5 clk = ~clk;
  assign sdi = master_m ? sdo : tb_sdi;

  spi_xfer_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .master_i(master_m), .irq_en_i(irq_en),
    .reg_sel_i(sel), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .irq_ack_i(ack), .sck_o(sck),
    .sck_i(sck_ext), .ss_n_i(ss_n), .sdo_o(sdo), .sdi_i(sdi));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic reg_write(input logic s, input logic [7:0] d);
    @(negedge clk); sel = s; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_read(input logic s, output logic [7:0] d);
    @(negedge clk); sel = s; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  // driver: every started byte is expected back on the wire and in the buffer
  task automatic send_byte(input logic [7:0] b);
    exp_q.push_back(b);
    reg_write(1'b1, b);
  endtask

  task automatic wait_irq();
    wait (irq === 1'b1);
    @(negedge clk);
  endtask

  // monitor: rebuild each master byte from the serial clock rising edges
  always @(posedge sck) begin
    if (mon_bits != 0) last_per = $time - last_rise;
    last_rise = $time;
    mon_byte = {mon_byte[6:0], sdo};
    mon_bits++;
    if (mon_bits == 8) begin
      mon_bits = 0;
      if (exp_q.size() == 0) chk(0, "R1 unexpected byte", mon_byte, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(mon_byte == e, "R1 serial byte msb first", mon_byte, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    logic [7:0] v, cap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    reg_read(1'b0, v); chk(v == 8'h00, "R10 status after reset", v, 8'h00);
    chk(irq == 1'b0 && sck == 1'b0, "R10/R1 irq and sck idle", {irq, sck}, 0);
    reg_write(1'b0, 8'hFF);
    reg_read(1'b0, v); chk(v == 8'h01, "R10 only bit0 writable", v, 8'h01);
    reg_write(1'b0, 8'h00);

    // R1 R2 R4 R8 R5: normal-speed byte and two-step clear
    send_byte(8'hA5); wait_irq();
    chk(last_per == 40, "R2 slow period ns", int'(last_per), 40);
    chk(irq == 1'b1, "R8 irq with enable", irq, 1);
    reg_read(1'b0, v); chk(v == 8'h80, "R4 completion flag", v, 8'h80);
    reg_read(1'b1, v); chk(v == 8'hA5, "R1 loop-back data", v, 8'hA5);
    reg_read(1'b0, v); chk(v == 8'h00, "R5 cleared after sequence", v, 8'h00);

    // R5 data access without status read keeps the flag; R2 fast speed
    send_byte(8'h3C); wait_irq();
    reg_read(1'b1, v); chk(v == 8'h3C, "R3 data read", v, 8'h3C);
    reg_read(1'b0, v); chk(v == 8'h80, "R5 unarmed data read keeps flag", v, 8'h80);
    reg_write(1'b0, 8'h01);
    send_byte(8'h5A);
    reg_read(1'b0, v); chk(v == 8'h01, "R5 armed write clears flag", v, 8'h01);
    wait_irq();
    chk(last_per == 20, "R2 fast period ns", int'(last_per), 20);
    reg_read(1'b0, v); chk(v == 8'h81, "R4 flag at fast speed", v, 8'h81);
    reg_read(1'b1, v); chk(v == 8'h5A, "R1 fast loop-back", v, 8'h5A);

    // R6 collision with per-flag arming
    send_byte(8'hC3);
    repeat (3) @(negedge clk);
    reg_write(1'b1, 8'h0F);
    reg_read(1'b0, v); chk(v == 8'h41, "R6 collision flag mid-transfer", v, 8'h41);
    wait_irq();
    reg_read(1'b1, v); chk(v == 8'hC3, "R6 byte unchanged by collision", v, 8'hC3);
    reg_read(1'b0, v); chk(v == 8'h81, "R5 only armed flag cleared", v, 8'h81);
    reg_read(1'b1, v);
    reg_read(1'b0, v); chk(v == 8'h01, "R5 both flags clear", v, 8'h01);
    reg_write(1'b0, 8'h00);

    // R7 acknowledge
    send_byte(8'h81); wait_irq();
    @(negedge clk); ack = 1'b1; @(negedge clk); ack = 1'b0;
    reg_read(1'b0, v); chk(v == 8'h00, "R7 ack clears flag", v, 8'h00);
    chk(irq == 1'b0, "R8 irq low after ack", irq, 0);

    // R8 enable gating
    irq_en = 1'b0;
    send_byte(8'h7E);
    repeat (60) @(negedge clk);
    chk(irq == 1'b0, "R8 irq masked", irq, 0);
    reg_read(1'b0, v); chk(v == 8'h80, "R4 flag while masked", v, 8'h80);
    irq_en = 1'b1; #1;
    chk(irq == 1'b1, "R8 irq on enable", irq, 1);
    reg_read(1'b1, v);

    // R9 forced flag from low select in master mode
    ss_n = 1'b0;
    repeat (6) @(negedge clk);
    reg_read(1'b0, v); chk(v == 8'h80, "R9 low select sets flag", v, 8'h80);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    reg_read(1'b1, v);
    reg_read(1'b0, v); chk(v == 8'h00, "R9 flag clears after release", v, 8'h00);

    // R3 buffer is not the live shift register
    send_byte(8'h11); wait_irq();
    reg_read(1'b0, v); reg_read(1'b1, v);
    send_byte(8'h22);
    repeat (10) @(negedge clk);
    reg_read(1'b1, v); chk(v == 8'h11, "R3 old byte during transfer", v, 8'h11);
    wait_irq();
    reg_read(1'b0, v); reg_read(1'b1, v); chk(v == 8'h22, "R3 new byte", v, 8'h22);

    // R11 slave exchange on external clock
    master_m = 1'b0;
    reg_write(1'b1, 8'h96);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    cap = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      tb_sdi = 8'(8'h3B >> i) != 8'h00 ? 8'(8'h3B >> i) & 8'h01 : 1'b0;
      repeat (8) @(negedge clk);
      sck_ext = 1'b1; cap = {cap[6:0], sdo};
      repeat (8) @(negedge clk);
      sck_ext = 1'b0;
    end
    repeat (6) @(negedge clk);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cap == 8'h96, "R11 slave sends loaded byte", cap, 8'h96);
    reg_read(1'b0, v); chk(v == 8'h80, "R11 slave completion", v, 8'h80);
    reg_read(1'b1, v); chk(v == 8'h3B, "R11 slave received byte", v, 8'h3B);
    chk(exp_q.size() == 0, "R1 all bytes seen", exp_q.size(), 0);
    finish_up();
  end
endmodule